// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block moves data between a narrow port A and a wide port B built from two narrow halves, called the first and second B halves. Going from A to B, two narrow words presented on A on consecutive load cycles come out side by side as one wide word on B. The first half's path has two register stages and the second half's path has one, so the earlier word and the later word line up.

Going from B to A, each B half has its own capture register. A select input then chooses which stored half appears on A. Every register captures on the rising clock edge, and only while its own active-low load enable is low.

Each port has a registered, active-low output-off control. The three-state pads are modelled outside the block: each output is a data bus plus a drive-enable signal. A synchronous active-high reset clears all data and turns both ports' drive off.

Top module: `bus_exchanger`

## Requirements
- R1: While reset is high at a rising edge, every data register clears to zero and both drive-enable outputs (`a_drv`, `b_drv`) go low.
- R2: The A-side staging register captures `a_in` at an edge where `ld1_n` is low. It keeps its value while `ld1_n` is high. It is observed on `b1_out` after the next `ld2_n` load.
- R3: At an edge where `ld2_n` is low, `b1_out` takes the staged word and `b2_out` takes `a_in`. While `ld2_n` is high, both B outputs hold.
- R4: `ld1_n` low with word w0 on one edge, followed by `ld2_n` low with word w1 on the next edge, leaves `b1_out`=w0 and `b2_out`=w1.
- R5: With `ld1_n` and `ld2_n` both low on the same edge, `b1_out` gets the word staged before that edge, while `b2_out` and the staging register both get `a_in`.
- R6: An edge with `cap1_n` low stores `b1_in`. An edge with `cap2_n` low stores `b2_in`. A store whose enable is high keeps its value.
- R7: `a_out` shows the first-half store when `sel` is 1 and the second-half store when `sel` is 0. It follows a `sel` change with no clock edge.
- R8: `a_drv` equals the inverse of `oe_a_n` as sampled at the most recent edge. A change of `oe_a_n` between edges has no effect on `a_drv`.
- R9: `b_drv` equals the inverse of `oe_b_n` as sampled at the most recent edge. A change of `oe_b_n` between edges has no effect on `b_drv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | NW | Narrow word arriving from port A |
| a_out | output | NW | Narrow word driven toward port A |
| a_drv | output | 1 | Drive enable for port A pads |
| oe_a_n | input | 1 | Active-low output-on request for A, registered |
| oe_b_n | input | 1 | Active-low output-on request for B, registered |
| ld1_n | input | 1 | Active-low load of the A staging register |
| ld2_n | input | 1 | Active-low load of both B output registers |
| cap1_n | input | 1 | Active-low capture of the first B half |
| cap2_n | input | 1 | Active-low capture of the second B half |
| sel | input | 1 | 1 picks first-half store for A, 0 picks second |
| b1_in | input | NW | First B half arriving from port B |
| b2_in | input | NW | Second B half arriving from port B |
| b1_out | output | NW | First B half driven toward port B |
| b2_out | output | NW | Second B half driven toward port B |
| b_drv | output | 1 | Drive enable for port B pads |

## Verification
All four output-enable combinations are swept. The bench reads the drive signals both before and after an edge, which separates a registered control from a combinational one.

Sixteen pairs of distinct arithmetic words go through the two-step load. A swapped or missing pipeline stage puts the wrong word in a half. Overlapped loads and long idle gaps separate the shared-edge case from plain holding.

The B-to-A sweep walks every capture-enable pattern. It toggles `sel` with no clock, which shows the choice is combinational and that each store holds on its own.

// File: rtl/bxch_pkg.sv
package bxch_pkg;

    typedef enum logic {
        PICK_2B = 1'b0,
        PICK_1B = 1'b1
    } pick_e;

    typedef struct packed {
        logic a_off;
        logic b_off;
    } oe_state_t;

    localparam oe_state_t OE_ALL_OFF = '{a_off: 1'b1, b_off: 1'b1};

    function automatic logic drive_of(input logic off);
        return !off;
    endfunction

endpackage

// File: rtl/bx_en_reg.sv
module bx_en_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (!en_n)
            q <= d;
    end
endmodule

// File: rtl/bx_a2b.sv
module bx_a2b #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic         ld1_n,
    input  logic         ld2_n,
    output logic [W-1:0] b1_q,
    output logic [W-1:0] b2_q
);
    logic [W-1:0] stage_q;

    // first of two stages toward half 1
    bx_en_reg #(.W(W)) u_stage (
        .clk(clk), .rst(rst), .en_n(ld1_n), .d(a_in), .q(stage_q)
    );

    // second stage toward half 1, released together with half 2
    bx_en_reg #(.W(W)) u_half1 (
        .clk(clk), .rst(rst), .en_n(ld2_n), .d(stage_q), .q(b1_q)
    );

    // single stage toward half 2
    bx_en_reg #(.W(W)) u_half2 (
        .clk(clk), .rst(rst), .en_n(ld2_n), .d(a_in), .q(b2_q)
    );

    p_stage_load_r2: assert property (@(posedge clk) disable iff (rst)
        !ld1_n |=> stage_q == $past(a_in));

    p_stage_hold_r2: assert property (@(posedge clk) disable iff (rst)
        ld1_n |=> $stable(stage_q));

    p_wide_load_r3: assert property (@(posedge clk) disable iff (rst)
        !ld2_n |=> (b1_q == $past(stage_q)) && (b2_q == $past(a_in)));

    p_wide_hold_r3: assert property (@(posedge clk) disable iff (rst)
        ld2_n |=> $stable(b1_q) && $stable(b2_q));
endmodule

// File: rtl/bx_b2a.sv
module bx_b2a
    import bxch_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] b1_in,
    input  logic [W-1:0] b2_in,
    input  logic         cap1_n,
    input  logic         cap2_n,
    input  logic         sel,
    output logic [W-1:0] a_q
);
    localparam int HALVES = 2;

    logic [HALVES-1:0][W-1:0] src;
    logic [HALVES-1:0][W-1:0] held;
    logic [HALVES-1:0]        cap_n;

    assign src[0]   = b1_in;
    assign src[1]   = b2_in;
    assign cap_n[0] = cap1_n;
    assign cap_n[1] = cap2_n;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        bx_en_reg #(.W(W)) u_cap (
            .clk(clk), .rst(rst), .en_n(cap_n[h]), .d(src[h]), .q(held[h])
        );
    end

    pick_e pick;
    assign pick = pick_e'(sel);

    always_comb begin
        unique case (pick)
            PICK_1B: a_q = held[0];
            default: a_q = held[1];
        endcase
    end

    p_cap1_r6: assert property (@(posedge clk) disable iff (rst)
        !cap1_n |=> held[0] == $past(b1_in));

    p_cap2_r6: assert property (@(posedge clk) disable iff (rst)
        !cap2_n |=> held[1] == $past(b2_in));

    p_cap_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cap1_n && cap2_n) |=> $stable(held));
endmodule

// File: rtl/bx_oe_ctl.sv
module bx_oe_ctl
    import bxch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic oe_a_n,
    input  logic oe_b_n,
    output logic a_drv,
    output logic b_drv
);
    oe_state_t st;

    always_ff @(posedge clk) begin
        if (rst)
            st <= OE_ALL_OFF;
        else
            st <= '{a_off: oe_a_n, b_off: oe_b_n};
    end

    assign a_drv = drive_of(st.a_off);
    assign b_drv = drive_of(st.b_off);

    p_a_drv_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> a_drv == !$past(oe_a_n));

    p_b_drv_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> b_drv == !$past(oe_b_n));

    p_reset_off_r1: assert property (@(posedge clk)
        rst |=> !a_drv && !b_drv);
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger #(
    parameter int NW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NW-1:0] a_in,
    output logic [NW-1:0] a_out,
    output logic          a_drv,
    input  logic          oe_a_n,
    input  logic          oe_b_n,
    input  logic          ld1_n,
    input  logic          ld2_n,
    input  logic          cap1_n,
    input  logic          cap2_n,
    input  logic          sel,
    input  logic [NW-1:0] b1_in,
    input  logic [NW-1:0] b2_in,
    output logic [NW-1:0] b1_out,
    output logic [NW-1:0] b2_out,
    output logic          b_drv
);
    bx_a2b #(.W(NW)) u_a2b (
        .clk(clk), .rst(rst), .a_in(a_in), .ld1_n(ld1_n), .ld2_n(ld2_n),
        .b1_q(b1_out), .b2_q(b2_out)
    );

    bx_b2a #(.W(NW)) u_b2a (
        .clk(clk), .rst(rst), .b1_in(b1_in), .b2_in(b2_in),
        .cap1_n(cap1_n), .cap2_n(cap2_n), .sel(sel), .a_q(a_out)
    );

    bx_oe_ctl u_oe (
        .clk(clk), .rst(rst), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .a_drv(a_drv), .b_drv(b_drv)
    );

    p_reset_data_r1: assert property (@(posedge clk)
        rst |=> (b1_out == '0) && (b2_out == '0) && (a_out == '0));
endmodule

// File: tb/bus_exchanger_tb.sv
module bus_exchanger_tb_top;
    localparam int NW = 12;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NW-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic oe_a_n = 1'b1, oe_b_n = 1'b1;
    logic ld1_n = 1'b1, ld2_n = 1'b1, cap1_n = 1'b1, cap2_n = 1'b1, sel = 1'b0;
    logic [NW-1:0] a_out, b1_out, b2_out;
    logic a_drv, b_drv;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // behavioural model state
    logic [NW-1:0] m_stage = '0, m_b1 = '0, m_b2 = '0, m_r1 = '0, m_r2 = '0;
    logic m_oea = 1'b1, m_oeb = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_exchanger #(.NW(NW)) dut_i (
        .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .ld1_n(ld1_n), .ld2_n(ld2_n),
        .cap1_n(cap1_n), .cap2_n(cap2_n), .sel(sel), .b1_in(b1_in),
        .b2_in(b2_in), .b1_out(b1_out), .b2_out(b2_out), .b_drv(b_drv)
    );

    task automatic chk(input string tag, input logic [NW-1:0] act, input logic [NW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [NW-1:0] exp_a();
        return sel ? m_r1 : m_r2;
    endfunction

    task automatic check_all();
        chk("R3 b1_out", b1_out, m_b1);
        chk("R3 b2_out", b2_out, m_b2);
        chk("R7 a_out", a_out, exp_a());
        chk("R8 a_drv", {{(NW-1){1'b0}}, a_drv}, {{(NW-1){1'b0}}, !m_oea});
        chk("R9 b_drv", {{(NW-1){1'b0}}, b_drv}, {{(NW-1){1'b0}}, !m_oeb});
    endtask

    task automatic tick();
        logic [NW-1:0] n_stage, n_b1, n_b2, n_r1, n_r2;
        logic n_oea, n_oeb;
        if (rst) begin
            n_stage = '0; n_b1 = '0; n_b2 = '0; n_r1 = '0; n_r2 = '0;
            n_oea = 1'b1; n_oeb = 1'b1;
        end else begin
            n_stage = ld1_n ? m_stage : a_in;
            n_b1    = ld2_n ? m_b1 : m_stage;
            n_b2    = ld2_n ? m_b2 : a_in;
            n_r1    = cap1_n ? m_r1 : b1_in;
            n_r2    = cap2_n ? m_r2 : b2_in;
            n_oea   = oe_a_n;
            n_oeb   = oe_b_n;
        end
        @(posedge clk);
        #1;
        m_stage = n_stage; m_b1 = n_b1; m_b2 = n_b2; m_r1 = n_r1; m_r2 = n_r2;
        m_oea = n_oea; m_oeb = n_oeb;
        check_all();
    endtask

    function automatic logic [NW-1:0] word(input int i, input int k);
        return NW'((i * 273 + k * 1111 + 37) ^ (i << 7));
    endfunction

    initial begin
        // R1: reset state
        a_in = 12'hFFF; b1_in = 12'hABC; b2_in = 12'h123;
        ld1_n = 1'b0; ld2_n = 1'b0; cap1_n = 1'b0; cap2_n = 1'b0;
        oe_a_n = 1'b0; oe_b_n = 1'b0;
        tick(); tick();
        chk("R1 b1_out zero", b1_out, '0);
        chk("R1 a_drv off", {{(NW-1){1'b0}}, a_drv}, '0);
        chk("R1 b_drv off", {{(NW-1){1'b0}}, b_drv}, '0);
        rst = 1'b0;
        ld1_n = 1'b1; ld2_n = 1'b1; cap1_n = 1'b1; cap2_n = 1'b1;
        oe_a_n = 1'b1; oe_b_n = 1'b1;
        tick();

        // R8 R9: all output-enable combinations; no effect between edges
        for (int c = 0; c < 4; c++) begin
            oe_a_n = c[0]; oe_b_n = c[1];
            #1;
            check_all();   // still previous registered values
            tick();
            chk("R8 a_drv follows", {{(NW-1){1'b0}}, a_drv}, {{(NW-1){1'b0}}, !c[0]});
            chk("R9 b_drv follows", {{(NW-1){1'b0}}, b_drv}, {{(NW-1){1'b0}}, !c[1]});
        end

        // R4: sequential pairs become one wide word
        for (int i = 0; i < 16; i++) begin
            logic [NW-1:0] w0, w1;
            w0 = word(i, 1); w1 = word(i, 2);
            a_in = w0; ld1_n = 1'b0; ld2_n = 1'b1;
            tick();
            a_in = w1; ld1_n = 1'b1; ld2_n = 1'b0;
            tick();
            chk("R4 first half", b1_out, w0);
            chk("R4 second half", b2_out, w1);
            ld2_n = 1'b1;
        end

        // R2 R3: staging holds across idle cycles, outputs hold while ld2_n high
        for (int i = 0; i < 8; i++) begin
            logic [NW-1:0] w0;
            w0 = word(i, 5);
            a_in = w0; ld1_n = 1'b0;
            tick();
            ld1_n = 1'b1;
            for (int g = 0; g < 3; g++) begin
                a_in = word(i + g, 9);
                tick();   // b outputs checked to hold inside
            end
            ld2_n = 1'b0; a_in = word(i, 7);
            tick();
            chk("R2 staged word held", b1_out, w0);
            ld2_n = 1'b1;
        end

        // R5: both loads on the same edge
        for (int i = 0; i < 8; i++) begin
            logic [NW-1:0] prev;
            prev = m_stage;
            a_in = word(i, 11); ld1_n = 1'b0; ld2_n = 1'b0;
            tick();
            chk("R5 first half gets old stage", b1_out, prev);
            chk("R5 second half gets input", b2_out, word(i, 11));
        end
        ld1_n = 1'b1; ld2_n = 1'b1;

        // R6 R7: all capture-enable patterns, sel toggled without a clock
        for (int i = 0; i < 8; i++) begin
            for (int p = 0; p < 4; p++) begin
                b1_in = word(i, 20 + p); b2_in = word(i, 30 + p);
                cap1_n = p[0]; cap2_n = p[1];
                tick();
                cap1_n = 1'b1; cap2_n = 1'b1;
                sel = 1'b1; #1;
                chk("R7 sel high picks first store", a_out, m_r1);
                chk("R6 first store", a_out, m_r1);
                sel = 1'b0; #1;
                chk("R7 sel low picks second store", a_out, m_r2);
                chk("R6 second store", a_out, m_r2);
            end
        end

        // B-to-A activity leaves the wide outputs alone
        tick();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule